// File: doc/BRIEF.md
# UART Receiver Mute and Wake-Up Controller

This block sits beside the bit-level logic of a UART receiver. It holds the receive-enable, mute and interrupt-enable control bits. It decides for each received byte whether the byte reaches the data holding register or is dropped because the receiver is muted. The receiver core gives it two single-cycle pulses: one for a completed byte, with that byte's value, and one for a detected idle line. Software writes the control bits through a single write strobe. It reads the held byte with a read strobe and clears the sticky flags with a clear strobe.

While muted, the controller waits for one of two wake-up events, chosen by a mode input. In idle-line mode, an idle line releases mute. This only works if a byte has been delivered since the receiver was last enabled. In address-mark mode, a byte whose top bit is set releases mute, and that byte is delivered. Hardware clears the mute bit when it wakes. In address-mark mode, a software write to the mute bit has no effect while a byte is waiting to be read. A single interrupt line combines the receive-full and overrun flags with the idle flag, each group gated by its own enable.

Top module: `uart_rx_wake_ctrl`

## Requirements
- R1: After reset, every control bit (rx_en, mute, rx_ie, idle_ie), every flag (rx_full, overrun, idle_flag), rdata and irq read 0.
- R2: A cycle with cfg_wr=1 loads rx_en, rx_ie and idle_ie from the cfg_* inputs, and mute from cfg_mute unless R8 blocks it. The new values are visible after the next clock edge.
- R3: While rx_en=0, byte and idle pulses change no flag, no mute state and no data.
- R4: An unmuted, enabled byte pulse with rx_full=0 loads rdata with the byte and sets rx_full. A rd_data pulse clears rx_full. A rd_data pulse in the same cycle as a byte pulse frees the register, so the byte is accepted without overrun.
- R5: A delivered byte that arrives while rx_full=1 and no read is pending sets overrun and leaves rdata unchanged.
- R6: While mute=1, bytes are not delivered (R7 is the only exception) and idle pulses do not set idle_flag.
- R7: With wake_addr_mode=1 and mute=1, a byte with bit DATA_W-1 equal to 1 clears mute and is delivered as in R4/R5. A byte with that bit equal to 0 is dropped.
- R8: With wake_addr_mode=1, a cfg_wr while rx_full=1 leaves mute unchanged.
- R9: With wake_addr_mode=0 and mute=1, an idle pulse clears mute only if at least one byte has been delivered since rx_en last became 1. Otherwise mute stays 1.
- R10: An idle pulse while enabled and unmuted sets idle_flag. A flag_clr pulse clears overrun and idle_flag. A set in the same cycle wins over the clear.
- R11: irq is 1 exactly when (rx_ie and (rx_full or overrun)) or (idle_ie and idle_flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_rx_en | input | 1 | Receive enable value to write |
| cfg_mute | input | 1 | Mute value to write |
| cfg_rx_ie | input | 1 | Receive/overrun interrupt enable value to write |
| cfg_idle_ie | input | 1 | Idle interrupt enable value to write |
| wake_addr_mode | input | 1 | 1 = address-mark wake-up, 0 = idle-line wake-up |
| rx_byte_vld | input | 1 | Byte completed pulse from receiver core |
| rx_byte_data | input | DATA_W | Received byte value |
| rx_idle_det | input | 1 | Idle line detected pulse |
| rd_data | input | 1 | Data read strobe, clears rx_full |
| flag_clr | input | 1 | Clears overrun and idle_flag |
| rx_en | output | 1 | Receive enable state |
| mute | output | 1 | Mute state |
| rx_ie | output | 1 | Receive/overrun interrupt enable state |
| idle_ie | output | 1 | Idle interrupt enable state |
| rdata | output | DATA_W | Held received byte |
| rx_full | output | 1 | Receive data full flag |
| overrun | output | 1 | Overrun flag |
| idle_flag | output | 1 | Idle line flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench builds the block with its default DATA_W of 8, so bit 7 is the address mark. Byte values 0x85 and 0x12 straddle the mark and the wake decision. Because the width is narrow, the bench can pick every byte value by hand to tell delivered data apart from dropped data and from data held during overrun. Same-cycle read and arrival, writes blocked by a held byte, and idle-line release with and without a prior byte are each reached with a few short pulses.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

    typedef enum logic {
        WAKE_IDLE_LINE = 1'b0,
        WAKE_ADDR_MARK = 1'b1
    } wake_mode_e;

    typedef struct packed {
        logic rx_en;
        logic mute;
        logic rx_ie;
        logic idle_ie;
    } ctrl_t;

    typedef struct packed {
        logic full;
        logic ovr;
        logic idle;
        logic seen;   // a byte was delivered since enable
    } flags_t;

endpackage

// File: rtl/uart_wake_decide.sv
module uart_wake_decide
    import uart_wake_pkg::*;
(
    input  wake_mode_e mode,
    input  logic       rx_en,
    input  logic       mute,
    input  logic       seen,
    input  logic       byte_vld,
    input  logic       byte_msb,
    input  logic       idle_det,
    output logic       deliver,
    output logic       wake,
    output logic       idle_set
);
    logic byte_ok;
    logic idle_ok;
    logic addr_wake;
    logic line_wake;

    always_comb begin
        byte_ok   = byte_vld & rx_en;
        idle_ok   = idle_det & rx_en;
        addr_wake = (mode == WAKE_ADDR_MARK) & mute & byte_ok & byte_msb;
        line_wake = (mode == WAKE_IDLE_LINE) & mute & idle_ok & seen;
        wake      = addr_wake | line_wake;
        deliver   = byte_ok & (~mute | addr_wake);
        idle_set  = idle_ok & ~mute;
    end
endmodule

// File: rtl/uart_wake_irq.sv
module uart_wake_irq
    import uart_wake_pkg::*;
(
    input  ctrl_t  ctrl,
    input  flags_t flg,
    output logic   irq
);
    always_comb begin
        irq = (ctrl.rx_ie & (flg.full | flg.ovr)) | (ctrl.idle_ie & flg.idle);
    end
endmodule

// File: rtl/uart_rx_wake_ctrl.sv
module uart_rx_wake_ctrl
    import uart_wake_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rx_en,
    input  logic              cfg_mute,
    input  logic              cfg_rx_ie,
    input  logic              cfg_idle_ie,
    input  logic              wake_addr_mode,
    input  logic              rx_byte_vld,
    input  logic [DATA_W-1:0] rx_byte_data,
    input  logic              rx_idle_det,
    input  logic              rd_data,
    input  logic              flag_clr,
    output logic              rx_en,
    output logic              mute,
    output logic              rx_ie,
    output logic              idle_ie,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_full,
    output logic              overrun,
    output logic              idle_flag,
    output logic              irq
);
    localparam int MARK_BIT = DATA_W - 1;

    typedef struct packed {
        ctrl_t             ctrl;
        flags_t            flg;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t     s_d, s_q;
    wake_mode_e mode;
    logic       deliver, wake, idle_set;
    logic       full_after_rd;
    logic       mute_locked;

    assign mode = wake_mode_e'(wake_addr_mode);

    uart_wake_decide u_decide (
        .mode     (mode),
        .rx_en    (s_q.ctrl.rx_en),
        .mute     (s_q.ctrl.mute),
        .seen     (s_q.flg.seen),
        .byte_vld (rx_byte_vld),
        .byte_msb (rx_byte_data[MARK_BIT]),
        .idle_det (rx_idle_det),
        .deliver  (deliver),
        .wake     (wake),
        .idle_set (idle_set)
    );

    uart_wake_irq u_irq (
        .ctrl (s_q.ctrl),
        .flg  (s_q.flg),
        .irq  (irq)
    );

    always_comb begin
        s_d           = s_q;
        full_after_rd = s_q.flg.full & ~rd_data;
        mute_locked   = (mode == WAKE_ADDR_MARK) & s_q.flg.full;

        // software control write
        if (cfg_wr) begin
            s_d.ctrl.rx_en   = cfg_rx_en;
            s_d.ctrl.rx_ie   = cfg_rx_ie;
            s_d.ctrl.idle_ie = cfg_idle_ie;
            if (!mute_locked) begin
                s_d.ctrl.mute = cfg_mute;
            end
        end

        // hardware wake-up overrides the write
        if (wake) begin
            s_d.ctrl.mute = 1'b0;
        end

        // holding register and flags
        s_d.flg.full = full_after_rd;
        if (flag_clr) begin
            s_d.flg.ovr  = 1'b0;
            s_d.flg.idle = 1'b0;
        end
        if (deliver) begin
            s_d.flg.seen = 1'b1;
            if (full_after_rd) begin
                s_d.flg.ovr = 1'b1;
            end else begin
                s_d.flg.full = 1'b1;
                s_d.data     = rx_byte_data;
            end
        end
        if (idle_set) begin
            s_d.flg.idle = 1'b1;
        end

        // byte history restarts whenever the receiver is off
        if (!s_d.ctrl.rx_en) begin
            s_d.flg.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_en     = s_q.ctrl.rx_en;
    assign mute      = s_q.ctrl.mute;
    assign rx_ie     = s_q.ctrl.rx_ie;
    assign idle_ie   = s_q.ctrl.idle_ie;
    assign rdata     = s_q.data;
    assign rx_full   = s_q.flg.full;
    assign overrun   = s_q.flg.ovr;
    assign idle_flag = s_q.flg.idle;
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_rx_en,
    input logic              cfg_mute,
    input logic              cfg_rx_ie,
    input logic              cfg_idle_ie,
    input logic              wake_addr_mode,
    input logic              rx_byte_vld,
    input logic [DATA_W-1:0] rx_byte_data,
    input logic              rx_idle_det,
    input logic              rd_data,
    input logic              flag_clr,
    input logic              rx_en,
    input logic              mute,
    input logic              rx_ie,
    input logic              idle_ie,
    input logic [DATA_W-1:0] rdata,
    input logic              rx_full,
    input logic              overrun,
    input logic              idle_flag,
    input logic              irq
);
    AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_data && !flag_clr && (rx_byte_vld || rx_idle_det))
        |=> ($stable(rx_full) && $stable(idle_flag) && $stable(rdata))); // R3

    AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !(rx_en && rx_byte_vld)) |=> !rx_full); // R4

    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_data && rx_en && !mute && rx_byte_vld)
        |=> (overrun && $stable(rdata))); // R5

    AST_MUTE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && rx_byte_vld && !wake_addr_mode && !rd_data)
        |=> ($stable(rx_full) && $stable(rdata))); // R6

    AST_MUTE_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && rx_idle_det && !flag_clr)
        |=> (idle_flag == $past(idle_flag))); // R6

    AST_MARK_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && rx_en && wake_addr_mode && !rx_full && rx_byte_vld
         && rx_byte_data[DATA_W-1])
        |=> (!mute && rx_full && rdata == $past(rx_byte_data))); // R7

    AST_MUTE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wake_addr_mode && rx_full && !rx_byte_vld && !rx_idle_det)
        |=> (mute == $past(mute))); // R8

    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && (rx_full || overrun)) |-> irq); // R11

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !idle_ie) |-> !irq); // R11
endmodule

bind uart_rx_wake_ctrl uart_rx_wake_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_rx_wake_ctrl_test.sv
module uart_rx_wake_ctrl_test;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 0, cfg_rx_en = 0, cfg_mute = 0, cfg_rx_ie = 0, cfg_idle_ie = 0;
    logic              wake_addr_mode = 0;
    logic              rx_byte_vld = 0;
    logic [DATA_W-1:0] rx_byte_data = '0;
    logic              rx_idle_det = 0, rd_data = 0, flag_clr = 0;
    logic              rx_en, mute, rx_ie, idle_ie, rx_full, overrun, idle_flag, irq;
    logic [DATA_W-1:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_rx_wake_ctrl #(.DATA_W(DATA_W)) uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // each pulse task drives at a falling edge and returns one falling edge later
    task automatic cfg(logic en, logic mu, logic rie, logic iie);
        cfg_wr = 1; cfg_rx_en = en; cfg_mute = mu; cfg_rx_ie = rie; cfg_idle_ie = iie;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic send(logic [DATA_W-1:0] b);
        rx_byte_vld = 1; rx_byte_data = b;
        @(negedge clk);
        rx_byte_vld = 0;
    endtask

    task automatic idle_pulse();
        rx_idle_det = 1;
        @(negedge clk);
        rx_idle_det = 0;
    endtask

    task automatic rd_pulse();
        rd_data = 1;
        @(negedge clk);
        rd_data = 0;
    endtask

    task automatic clr_pulse();
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 ctrl", {rx_en, mute, rx_ie, idle_ie}, 0);
        check("R1 flags", {rx_full, overrun, idle_flag, irq}, 0);
        check("R1 rdata", rdata, 0);
    endtask

    task automatic t_cfg();
        cfg(1, 0, 1, 0);
        check("R2 write", {rx_en, mute, rx_ie, idle_ie}, 4'b1010);
        cfg(1, 0, 0, 1);
        check("R2 rewrite", {rx_en, mute, rx_ie, idle_ie}, 4'b1001);
    endtask

    task automatic t_disabled();
        cfg(0, 0, 0, 0);
        send(8'h5A);
        idle_pulse();
        check("R3 off byte", {rx_full, rdata}, 0);
        check("R3 off idle", idle_flag, 0);
    endtask

    task automatic t_active();
        wake_addr_mode = 0;
        cfg(1, 0, 0, 0);
        send(8'h3C);
        check("R4 deliver", {rx_full, rdata}, {1'b1, 8'h3C});
        send(8'h77);
        check("R5 overrun", {overrun, rdata}, {1'b1, 8'h3C});
        rd_pulse();
        check("R4 read", rx_full, 0);
        clr_pulse();
        check("R10 clr ovr", overrun, 0);
        send(8'h11);
        rd_data = 1; rx_byte_vld = 1; rx_byte_data = 8'h22;
        @(negedge clk);
        rd_data = 0; rx_byte_vld = 0;
        check("R4 same cycle", {rx_full, overrun, rdata}, {2'b10, 8'h22});
        rd_pulse();
    endtask

    task automatic t_idle();
        idle_pulse();
        check("R10 idle set", idle_flag, 1);
        flag_clr = 1; rx_idle_det = 1;
        @(negedge clk);
        flag_clr = 0; rx_idle_det = 0;
        check("R10 set wins", idle_flag, 1);
        clr_pulse();
        check("R10 clr idle", idle_flag, 0);
    endtask

    task automatic t_irq();
        cfg(1, 0, 1, 0);
        check("R11 quiet", irq, 0);
        send(8'h01);
        check("R11 full irq", irq, 1);
        rd_pulse();
        check("R11 read drops", irq, 0);
        cfg(1, 0, 0, 1);
        idle_pulse();
        check("R11 idle irq", irq, 1);
        clr_pulse();
        check("R11 clr drops", irq, 0);
        cfg(1, 0, 0, 0);
    endtask

    task automatic t_idle_wake();
        wake_addr_mode = 0;
        cfg(0, 0, 0, 0);
        cfg(1, 1, 0, 0);
        check("R2 mute set", mute, 1);
        idle_pulse();
        check("R9 no prior byte", {mute, idle_flag}, 2'b10);
        send(8'hF0);
        check("R6 muted drop", rx_full, 0);
        cfg(1, 0, 0, 0);
        send(8'h44);
        rd_pulse();
        cfg(1, 1, 0, 0);
        idle_pulse();
        check("R9 idle wakes", {mute, idle_flag}, 2'b00);
    endtask

    task automatic t_addr_wake();
        wake_addr_mode = 1;
        cfg(1, 1, 0, 0);
        send(8'h12);
        check("R7 plain byte", {mute, rx_full}, 2'b10);
        send(8'h85);
        check("R7 mark wakes", {mute, rx_full, rdata}, {2'b01, 8'h85});
        cfg(1, 1, 0, 0);
        check("R8 locked", mute, 0);
        rd_pulse();
        cfg(1, 1, 0, 0);
        check("R8 unlocked", mute, 1);
        idle_pulse();
        check("R6 addr idle", {mute, idle_flag}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_cfg();
        t_disabled();
        t_active();
        t_idle();
        t_irq();
        t_idle_wake();
        t_addr_wake();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule